// File: doc/BRIEF.md
# Two-Wire Bus State and Timeout Monitor

This block sits beside a two-wire serial bus controller and watches the clock line (SCL) and data line (SDA) after synchronizing them into the system clock domain. It detects START and STOP conditions and keeps a busy flag. It also decides when an idle bus may be treated as free without a STOP: both lines must stay high for more than ten periods of a selectable tick source. A seven-bit configuration register selects the tick source and enables each feature. The busy flag appears in bit 5 of the read-back word, and that bit cannot be written.

For detection of a stuck-low clock, the block drives two controls to an external timeout counter. One holds the counter in reload while SCL is high. The other lets it count while SCL is low. The block also merges slave-event and master-event requests into one registered interrupt, and it can suppress slave events. The hold-extension bit is passed out as a flag for the bit-timing logic and has no effect inside this block.

Top module: `smb_bus_monitor`

## Requirements
- R1: After reset, cfg_rdata is 0x00, and bus_busy, free_timeout, to_reload, to_count_en, irq_out and hold_ext are all 0.
- R2: While the enable bit (bit 7) is 0, a START does not set busy, to_reload and to_count_en stay 0, and irq_out stays 0 for both slave and master events.
- R3: When SDA falls while SCL is high on the synchronized lines, bus_busy and cfg_rdata bit 5 become 1.
- R4: When SDA rises while SCL is high (a STOP), busy is cleared. When SDA rises while SCL is low, busy is unchanged.
- R5: With free-timeout detection enabled (bit 2), free_timeout goes to 1 and busy clears on the 11th selected tick counted while both lines are high. After only 10 such ticks, free_timeout is still 0 and busy is still set.
- R6: A low level on either line clears the tick count, so a further 11 ticks are needed before free_timeout is asserted.
- R7: Bits 1:0 select the tick input: 00 tick_t0_ovf, 01 tick_t1_ovf, 10 tick_t2h_ovf, 11 tick_t2l_ovf. Ticks on inputs that are not selected are not counted.
- R8: With bit 2 at 0, free_timeout stays 0 and busy stays set regardless of the number of ticks.
- R9: With enable and SCL-timeout enable (bit 3) both set, to_reload is 1 while SCL is high and to_count_en is 1 while SCL is low. The two are never 1 together, and both are 0 when bit 3 is 0.
- R10: When slave inhibit (bit 6) is 1, slave_evt_in does not raise irq_out, while master_evt_in still does. When bit 6 is 0, slave_evt_in raises irq_out one cycle later.
- R11: The read-back layout is {enable, slave inhibit, busy, hold extension, SCL timeout enable, free timeout enable, select[1:0]} from bit 7 down to bit 0. A write to bit 5 is ignored.
- R12: hold_ext follows configuration bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration and busy read-back |
| tick_t0_ovf | input | 1 | Tick source, select 00 |
| tick_t1_ovf | input | 1 | Tick source, select 01 |
| tick_t2h_ovf | input | 1 | Tick source, select 10 |
| tick_t2l_ovf | input | 1 | Tick source, select 11 |
| slave_evt_in | input | 1 | Slave event request |
| master_evt_in | input | 1 | Master event request |
| irq_out | output | 1 | Registered interrupt |
| bus_busy | output | 1 | Transfer in progress |
| free_timeout | output | 1 | Bus declared free by timeout |
| hold_ext | output | 1 | Setup/hold extension flag |
| to_reload | output | 1 | Reload request to external SCL-low timer |
| to_count_en | output | 1 | Count enable to external SCL-low timer |

## Verification
The hardest state to reach is a busy bus with both lines idle high and no STOP, because free-timeout counting starts only from that state. The stimulus issues a START, lowers SCL, raises SDA while SCL is low, and then releases SCL. It then pulses the selected tick exactly ten and then eleven times, with the non-selected ticks interleaved. Pulling SCL low briefly in the middle of a count shows that the count restarts.

// File: rtl/smbmon_pkg.sv
package smbmon_pkg;
  typedef struct packed {
    logic       en;
    logic       inh;
    logic       ext;
    logic       ste;
    logic       fte;
    logic [1:0] cs;
  } smb_cfg_t;

  localparam int unsigned NUM_TICK_SRC = 4;
  localparam int unsigned SEL_W        = $clog2(NUM_TICK_SRC);
endpackage

// File: rtl/smbmon_sync.sv
module smbmon_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/smbmon_cond_detect.sv
module smbmon_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic lines_high_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_o      = en & scl_q & scl_s & sda_q & ~sda_s;
  assign stop_o       = en & scl_q & scl_s & ~sda_q & sda_s;
  assign lines_high_o = scl_s & sda_s;

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o)); // R4
endmodule

// File: rtl/smbmon_free_timer.sv
module smbmon_free_timer
  import smbmon_pkg::*;
#(
  parameter int FREE_PERIODS = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    fte,
  input  logic                    lines_high,
  input  logic [NUM_TICK_SRC-1:0] ticks,
  input  logic [SEL_W-1:0]        sel,
  output logic                    free_nxt,
  output logic                    free_to_q
);
  localparam int THR   = FREE_PERIODS + 1;
  localparam int CNT_W = $clog2(THR + 1);
  localparam logic [CNT_W-1:0] THR_V = CNT_W'(THR);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             tick_sel;

  assign tick_sel = ticks[sel];

  always_comb begin
    if (!(en && lines_high))                cnt_nxt = '0;
    else if (tick_sel && (cnt_q != THR_V))  cnt_nxt = cnt_q + 1'b1;
    else                                    cnt_nxt = cnt_q;
  end

  assign free_nxt = en & fte & (cnt_nxt == THR_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      free_to_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      free_to_q <= free_nxt;
    end
  end

  always_comb begin
    AST_CNT_SATURATES: assert (rst || cnt_q <= THR_V); // R5
  end

  AST_LOW_CLEARS_CNT: assert property (@(posedge clk) disable iff (rst)
    !lines_high |=> (cnt_q == '0)); // R6

  AST_NO_FTE_NO_FREE: assert property (@(posedge clk) disable iff (rst)
    !fte |=> !free_to_q); // R8
endmodule

// File: rtl/smb_bus_monitor.sv
module smb_bus_monitor
  import smbmon_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FREE_PERIODS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       tick_t0_ovf,
  input  logic       tick_t1_ovf,
  input  logic       tick_t2h_ovf,
  input  logic       tick_t2l_ovf,
  input  logic       slave_evt_in,
  input  logic       master_evt_in,
  output logic       irq_out,
  output logic       bus_busy,
  output logic       free_timeout,
  output logic       hold_ext,
  output logic       to_reload,
  output logic       to_count_en
);
  smb_cfg_t   cfg_q;
  logic [1:0] lines_s;
  logic       start_p, stop_p, lines_high;
  logic       free_nxt, free_to_q;
  logic       busy_q, reload_q, count_q, irq_q;
  logic       unused_wbit;

  assign unused_wbit = cfg_wdata[5];

  // configuration register, bit 5 is the read-only busy flag
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q.en  <= cfg_wdata[7];
      cfg_q.inh <= cfg_wdata[6];
      cfg_q.ext <= cfg_wdata[4];
      cfg_q.ste <= cfg_wdata[3];
      cfg_q.fte <= cfg_wdata[2];
      cfg_q.cs  <= cfg_wdata[1:0];
    end
  end

  smbmon_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_s)
  );

  smbmon_cond_detect cond_i (
    .clk          (clk),
    .rst          (rst),
    .en           (cfg_q.en),
    .scl_s        (lines_s[1]),
    .sda_s        (lines_s[0]),
    .start_o      (start_p),
    .stop_o       (stop_p),
    .lines_high_o (lines_high)
  );

  smbmon_free_timer #(.FREE_PERIODS(FREE_PERIODS)) free_i (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_q.en),
    .fte        (cfg_q.fte),
    .lines_high (lines_high),
    .ticks      ({tick_t2l_ovf, tick_t2h_ovf, tick_t1_ovf, tick_t0_ovf}),
    .sel        (cfg_q.cs),
    .free_nxt   (free_nxt),
    .free_to_q  (free_to_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      reload_q <= 1'b0;
      count_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (!cfg_q.en)              busy_q <= 1'b0;
      else if (start_p)           busy_q <= 1'b1;
      else if (stop_p || free_nxt) busy_q <= 1'b0;
      reload_q <= cfg_q.en & cfg_q.ste & lines_s[1];
      count_q  <= cfg_q.en & cfg_q.ste & ~lines_s[1];
      irq_q    <= cfg_q.en & (master_evt_in | (slave_evt_in & ~cfg_q.inh));
    end
  end

  assign cfg_rdata    = {cfg_q.en, cfg_q.inh, busy_q, cfg_q.ext,
                         cfg_q.ste, cfg_q.fte, cfg_q.cs};
  assign bus_busy     = busy_q;
  assign free_timeout = free_to_q;
  assign hold_ext     = cfg_q.ext;
  assign to_reload    = reload_q;
  assign to_count_en  = count_q;
  assign irq_out      = irq_q;

  AST_DISABLED_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.en |=> !busy_q); // R2
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_p |=> busy_q); // R3
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !busy_q); // R4
  AST_TIMER_CTRL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(to_reload && to_count_en)); // R9
  AST_INHIBIT_SLAVE: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.inh && !master_evt_in) |=> !irq_out); // R10
endmodule

// File: tb/smb_bus_monitor_tb.sv
module smb_bus_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1, sda = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] tk = '0;
  logic       sev = 1'b0, mev = 1'b0;
  logic       irq, busy, fto, hext, rld, cen;
  int         checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  smb_bus_monitor dut_i (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tick_t0_ovf(tk[0]), .tick_t1_ovf(tk[1]), .tick_t2h_ovf(tk[2]), .tick_t2l_ovf(tk[3]),
    .slave_evt_in(sev), .master_evt_in(mev), .irq_out(irq), .bus_busy(busy),
    .free_timeout(fto), .hold_ext(hext), .to_reload(rld), .to_count_en(cen)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 50000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    waitn(1);
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      tk[which] = 1'b1; @(negedge clk);
      tk[which] = 1'b0; @(negedge clk);
    end
  endtask

  task automatic lines(input logic c, input logic d);
    scl = c; sda = d; waitn(5);
  endtask

  // busy bus, both lines high, no STOP seen
  task automatic make_busy_idle();
    lines(1, 1);
    lines(1, 0);
    lines(0, 0);
    lines(0, 1);
    lines(1, 1);
  endtask

  task automatic do_stop();
    lines(0, 1); lines(0, 0); lines(1, 0); lines(1, 1);
  endtask

  task automatic t_reset();
    chk("R1 rdata", cfg_rdata, 8'h00);
    chk("R1 busy", busy, 0); chk("R1 fto", fto, 0);
    chk("R1 reload", rld, 0); chk("R1 count", cen, 0);
    chk("R1 irq", irq, 0); chk("R1 hold", hext, 0);
  endtask

  task automatic t_disabled();
    wcfg(8'h08);
    lines(1, 0);
    chk("R2 start ignored", busy, 0);
    lines(0, 0);
    chk("R2 count_en off", cen, 0);
    chk("R2 reload off", rld, 0);
    lines(1, 1);
    sev = 1'b1; mev = 1'b1; waitn(2);
    chk("R2 irq off", irq, 0);
    sev = 1'b0; mev = 1'b0; waitn(2);
  endtask

  task automatic t_layout();
    wcfg(8'hFF);
    chk("R11 layout busy ro", cfg_rdata, 8'hDF);
    chk("R12 hold on", hext, 1);
    wcfg(8'h80);
    chk("R11 layout", cfg_rdata, 8'h80);
    chk("R12 hold off", hext, 0);
  endtask

  task automatic t_start_stop();
    wcfg(8'h80);
    lines(1, 1); lines(1, 0);
    chk("R3 busy set", busy, 1);
    chk("R3 rdata bit5", cfg_rdata[5], 1);
    lines(0, 0); lines(0, 1); lines(1, 1);
    chk("R4 rise scl low keeps busy", busy, 1);
    do_stop();
    chk("R4 stop clears", busy, 0);
  endtask

  task automatic t_free();
    wcfg(8'h84);
    make_busy_idle();
    pulse(1, 12);
    chk("R7 unselected ignored", fto, 0);
    pulse(0, 10);
    chk("R5 ten ticks no timeout", fto, 0);
    chk("R5 ten ticks still busy", busy, 1);
    pulse(0, 1);
    chk("R5 eleventh tick timeout", fto, 1);
    chk("R5 busy cleared", busy, 0);
  endtask

  task automatic t_restart();
    lines(0, 1); lines(1, 1);
    wcfg(8'h86);
    make_busy_idle();
    pulse(2, 6);
    lines(0, 1); lines(1, 1);
    pulse(0, 5);
    pulse(2, 10);
    chk("R6 restart ten ticks", fto, 0);
    pulse(2, 1);
    chk("R6 restart eleventh", fto, 1);
    lines(0, 1); lines(1, 1);
    wcfg(8'h87);
    pulse(3, 11);
    chk("R7 select 11 uses t2l", fto, 1);
  endtask

  task automatic t_nofte();
    lines(0, 1); lines(1, 1);
    wcfg(8'h80);
    make_busy_idle();
    pulse(0, 15);
    chk("R8 no timeout", fto, 0);
    chk("R8 busy held", busy, 1);
    do_stop();
  endtask

  task automatic t_scl_to();
    wcfg(8'h88);
    lines(1, 1);
    chk("R9 reload high", rld, 1); chk("R9 count off high", cen, 0);
    lines(0, 1);
    chk("R9 reload off low", rld, 0); chk("R9 count low", cen, 1);
    wcfg(8'h80);
    waitn(2);
    chk("R9 disabled count", cen, 0); chk("R9 disabled reload", rld, 0);
    lines(1, 1);
  endtask

  task automatic t_irq();
    wcfg(8'hC0);
    sev = 1'b1; waitn(1);
    chk("R10 inhibited slave", irq, 0);
    sev = 1'b0; mev = 1'b1; waitn(1);
    chk("R10 master passes", irq, 1);
    mev = 1'b0; waitn(1);
    wcfg(8'h80);
    sev = 1'b1; waitn(1);
    chk("R10 slave passes", irq, 1);
    sev = 1'b0; waitn(1);
    chk("R10 irq drops", irq, 0);
  endtask

  initial begin
    waitn(3);
    rst = 1'b0;
    waitn(1);
    t_reset();
    t_disabled();
    t_layout();
    t_start_stop();
    t_free();
    t_restart();
    t_nofte();
    t_scl_to();
    t_irq();
    summary();
  end
endmodule